// File: doc/BRIEF.md
# Display Timing Enable Chain

This block turns one master clock into the stacked timing enables that drive a raster display pipeline. A dot enable divides the master clock by one or two. A character enable counts eight or nine dots. From the character enable come two more strobes: one that advances the memory address counter and one that loads the pixel serializer. Each can be divided by one, two or four. At the line level, the rising edges of the horizontal retrace input become a vertical count enable, optionally halved, and a row scan enable, which can be halved again for scan doubling.

Every output is a single-cycle enable in the master clock domain. Downstream counters use these strobes as clock enables and are not clocked by derived clocks. All control bits are sampled at character boundaries. A control change therefore never cuts a character short. After reset every divider starts at phase zero.

Top module: `disp_clk_chain`

## Requirements
- R1: With `dot_half`=0 `dot_en` is high on every cycle; with `dot_half`=1 it is high on alternate cycles, starting with the first cycle after reset.
- R2: `char_en` is high on the first dot of each character; a character lasts 8 dots when `eight_dot`=1 and 9 dots when `eight_dot`=0.
- R3: With exactly one or neither of `adr_div2`/`adr_div4` set, `adr_en` is high on every character enable (neither set), on every second one (`adr_div2` only) or on every fourth one (`adr_div4` only), counting characters from 0 after reset and firing on character indices divisible by the divisor.
- R4: With both `adr_div2` and `adr_div4` set, `adr_en` is high on the dot enables of dot index 0 and dot index 4 of every character, in both 8-dot and 9-dot modes.
- R5: `load_en` is high on every character enable when `sh_load`=0 and `sh_four`=0, on characters with index divisible by 2 when `sh_load`=1 and `sh_four`=0, and on those divisible by 4 when `sh_four`=1.
- R6: `vcnt_en` pulses one cycle after each rising edge of `hretrace` is sampled; with `line_div2`=1 only the 1st, 3rd, 5th… rising edges after reset produce a pulse.
- R7: `row_en` pulses together with `vcnt_en`; with `scan_dbl`=1 only the 1st, 3rd, 5th… vertical count enables after reset are passed.
- R8: While `rst_n` is low all outputs are low; the first cycle after reset is dot 0 of character 0, so `dot_en`, `char_en`, `adr_en` and `load_en` are all high in it.
- R9: A control bit changed in the middle of a character takes effect from the next character start; the current character keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dot_half | input | 1 | 1: dot rate is half the master clock |
| eight_dot | input | 1 | 1: 8-dot characters, 0: 9-dot characters |
| adr_div2 | input | 1 | Address advance every second character |
| adr_div4 | input | 1 | Address advance every fourth character |
| sh_load | input | 1 | Serializer load every second character |
| sh_four | input | 1 | Serializer load every fourth character |
| line_div2 | input | 1 | Vertical count on every second retrace |
| scan_dbl | input | 1 | Row scan on every second vertical count |
| hretrace | input | 1 | Horizontal retrace level; its rising edges are counted |
| dot_en | output | 1 | Dot clock enable |
| char_en | output | 1 | Character clock enable |
| adr_en | output | 1 | Memory address counter advance enable |
| load_en | output | 1 | Serializer load enable |
| vcnt_en | output | 1 | Vertical counter enable |
| row_en | output | 1 | Row scan counter enable |

## Verification
The assertions assume that the control bits are sampled only at the character boundary. A dot-rate pattern is therefore checked against the configuration that is held inside the block, and not against the pins. They also assume that `hretrace` is a level whose rising edges mark lines. Each sweep applies its control settings before reset is released, so the first character already runs under them. Only the boundary test changes a control bit in the middle of a run. The retrace stimulus uses isolated one-cycle pulses separated by several low cycles, so every rising edge is clean and is seen once.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
  localparam int SEQ_W = 2;

  typedef struct packed {
    logic dot_half;
    logic eight_dot;
    logic adr_div2;
    logic adr_div4;
    logic sh_load;
    logic sh_four;
    logic line_div2;
    logic scan_dbl;
  } dcc_cfg_t;

  // dots per character
  function automatic logic [3:0] char_len(input logic eight);
    return eight ? 4'd8 : 4'd9;
  endfunction

  // divide-by-1/2/4 selection on a character sequence number
  function automatic logic seq_pick(input logic by2, input logic by4,
                                    input logic [SEQ_W-1:0] seq);
    if (by4)      return seq == '0;
    else if (by2) return ~seq[0];
    else          return 1'b1;
  endfunction
endpackage

// File: rtl/dcc_dot_stage.sv
`timescale 1ns/1ps
module dcc_dot_stage
  import dcc_pkg::*;
#(
  parameter int DOT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  dcc_cfg_t         cfg_in,
  output dcc_cfg_t         cfg,
  output logic             dot_en,
  output logic             char_en,
  output logic             char_wrap,
  output logic [DOT_W-1:0] dot_idx
);
  localparam int CNT_W = DOT_W + 1;

  logic             ph;
  logic [DOT_W-1:0] dcnt;
  logic             dot_end;
  logic [DOT_W-1:0] last_dot;

  assign last_dot  = DOT_W'(char_len(cfg.eight_dot) - 4'd1);
  assign dot_en    = live & (~cfg.dot_half | ~ph);
  assign dot_end   = live & (~cfg.dot_half | ph);
  assign char_wrap = dot_end & (dcnt == last_dot);
  assign char_en   = dot_en & (dcnt == '0);
  assign dot_idx   = dcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= 1'b0;
      dcnt <= '0;
      cfg  <= cfg_in;
    end else if (!live) begin
      cfg  <= cfg_in;
    end else begin
      if (cfg.dot_half) ph <= ~ph;
      if (char_wrap) begin
        dcnt <= '0;
        cfg  <= cfg_in;
      end else if (dot_end) begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  // checker state: dots seen since the last character start
  logic [CNT_W-1:0] seen_dots;
  logic [CNT_W-1:0] len_q;
  logic             had_char;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_dots <= '0;
      len_q     <= '0;
      had_char  <= 1'b0;
    end else if (char_en) begin
      seen_dots <= CNT_W'(1);
      len_q     <= CNT_W'(char_len(cfg.eight_dot));
      had_char  <= 1'b1;
    end else if (dot_en) begin
      seen_dots <= seen_dots + 1'b1;
    end
  end

  // R1
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dot_half && dot_en) |=> !dot_en);

  // R2
  char_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_en && had_char) |-> (seen_dots == len_q));
endmodule

// File: rtl/dcc_char_stage.sv
`timescale 1ns/1ps
module dcc_char_stage
  import dcc_pkg::*;
#(
  parameter int DOT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dot_en,
  input  logic             char_en,
  input  logic             char_wrap,
  input  logic [DOT_W-1:0] dot_idx,
  input  logic             adr_div2,
  input  logic             adr_div4,
  input  logic             sh_load,
  input  logic             sh_four,
  output logic             adr_en,
  output logic             load_en
);
  logic [SEQ_W-1:0] seq;
  logic             half_char;

  assign half_char = dot_en & ((dot_idx == '0) | (dot_idx == DOT_W'(4)));
  assign adr_en    = (adr_div2 & adr_div4) ? half_char
                   : (char_en & seq_pick(adr_div2, adr_div4, seq));
  assign load_en   = char_en & seq_pick(sh_load, sh_four, seq);

  always_ff @(posedge clk) begin
    if (!rst_n)         seq <= '0;
    else if (char_wrap) seq <= seq + 1'b1;
  end

  // R4
  adr_on_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_en |-> dot_en);

  // R5
  load_on_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> char_en);
endmodule

// File: rtl/dcc_line_stage.sv
`timescale 1ns/1ps
module dcc_line_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic hretrace,
  input  logic line_div2,
  input  logic scan_dbl,
  output logic vcnt_en,
  output logic row_en
);
  logic hr_q, lph, rph, hr_rise, v_pass, r_pass;

  assign hr_rise = live & hretrace & ~hr_q;
  assign v_pass  = hr_rise & (~line_div2 | ~lph);
  assign r_pass  = v_pass & (~scan_dbl | ~rph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr_q    <= 1'b0;
      lph     <= 1'b0;
      rph     <= 1'b0;
      vcnt_en <= 1'b0;
      row_en  <= 1'b0;
    end else begin
      hr_q    <= hretrace;
      vcnt_en <= v_pass;
      row_en  <= r_pass;
      if (hr_rise && line_div2) lph <= ~lph;
      if (v_pass && scan_dbl)   rph <= ~rph;
    end
  end

  // R6
  vcnt_after_hr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt_en |-> $past(hretrace));

  // R7
  row_in_vcnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_en |-> vcnt_en);
endmodule

// File: rtl/disp_clk_chain.sv
`timescale 1ns/1ps
module disp_clk_chain
  import dcc_pkg::*;
#(
  parameter int DOT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dot_half,
  input  logic eight_dot,
  input  logic adr_div2,
  input  logic adr_div4,
  input  logic sh_load,
  input  logic sh_four,
  input  logic line_div2,
  input  logic scan_dbl,
  input  logic hretrace,
  output logic dot_en,
  output logic char_en,
  output logic adr_en,
  output logic load_en,
  output logic vcnt_en,
  output logic row_en
);
  logic             live;
  dcc_cfg_t         cfg_in, cfg;
  logic             char_wrap;
  logic [DOT_W-1:0] dot_idx;

  assign cfg_in = '{dot_half: dot_half, eight_dot: eight_dot,
                    adr_div2: adr_div2, adr_div4: adr_div4,
                    sh_load: sh_load, sh_four: sh_four,
                    line_div2: line_div2, scan_dbl: scan_dbl};

  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  dcc_dot_stage #(.DOT_W(DOT_W)) dot_i (
    .clk(clk), .rst_n(rst_n), .live(live), .cfg_in(cfg_in), .cfg(cfg),
    .dot_en(dot_en), .char_en(char_en), .char_wrap(char_wrap),
    .dot_idx(dot_idx));

  dcc_char_stage #(.DOT_W(DOT_W)) chr_i (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .char_en(char_en),
    .char_wrap(char_wrap), .dot_idx(dot_idx),
    .adr_div2(cfg.adr_div2), .adr_div4(cfg.adr_div4),
    .sh_load(cfg.sh_load), .sh_four(cfg.sh_four),
    .adr_en(adr_en), .load_en(load_en));

  dcc_line_stage line_i (
    .clk(clk), .rst_n(rst_n), .live(live), .hretrace(hretrace),
    .line_div2(cfg.line_div2), .scan_dbl(cfg.scan_dbl),
    .vcnt_en(vcnt_en), .row_en(row_en));

  // R8
  quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!$past(rst_n) && !char_en && !vcnt_en) || $past(rst_n));
endmodule

// File: tb/disp_clk_chain_tb.sv
`timescale 1ns/1ps
module disp_clk_chain_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dot_half = 0, eight_dot = 0, adr_div2 = 0, adr_div4 = 0;
  logic sh_load = 0, sh_four = 0, line_div2 = 0, scan_dbl = 0, hretrace = 0;
  logic dot_en, char_en, adr_en, load_en, vcnt_en, row_en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  bit count_on = 0;
  int vc_seen = 0, row_seen = 0;

  always #10 clk = ~clk;

  disp_clk_chain dut_i (
    .clk(clk), .rst_n(rst_n), .dot_half(dot_half), .eight_dot(eight_dot),
    .adr_div2(adr_div2), .adr_div4(adr_div4), .sh_load(sh_load),
    .sh_four(sh_four), .line_div2(line_div2), .scan_dbl(scan_dbl),
    .hretrace(hretrace), .dot_en(dot_en), .char_en(char_en),
    .adr_en(adr_en), .load_en(load_en), .vcnt_en(vcnt_en), .row_en(row_en));

  always @(negedge clk) if (count_on) begin
    vc_seen  += int'(vcnt_en);
    row_seen += int'(row_en);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input int got, input int exp, input string req, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // apply controls in reset, release, land on the first live cycle (t=0)
  task automatic start(input logic [7:0] c);
    @(negedge clk);
    {dot_half, eight_dot, adr_div2, adr_div4, sh_load, sh_four, line_div2, scan_dbl} = c;
    hretrace = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  function automatic bit pick(input bit b2, input bit b4, input int seq);
    if (b4) return (seq % 4) == 0;
    if (b2) return (seq % 2) == 0;
    return 1'b1;
  endfunction

  initial begin
    // R8: outputs quiet during reset
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(int'(dot_en | char_en | adr_en | load_en | vcnt_en | row_en), 0, "R8", "outputs in reset");

    // near-exhaustive sweep of the character-level controls
    for (int cfgv = 0; cfgv < 64; cfgv++) begin
      bit h, e, a2, a4, sl, sf;
      int n;
      h  = cfgv[5]; e = cfgv[4]; a2 = cfgv[3]; a4 = cfgv[2]; sl = cfgv[1]; sf = cfgv[0];
      n  = e ? 8 : 9;
      start({h, e, a2, a4, sl, sf, 1'b0, 1'b0});
      for (int t = 0; t < 160; t++) begin
        int dt, di, ci;
        bit de, ce, ae, le;
        de = h ? (t % 2 == 0) : 1'b1;
        dt = h ? t / 2 : t;
        di = dt % n;
        ci = dt / n;
        ce = de && di == 0;
        ae = (a2 && a4) ? (de && (di == 0 || di == 4)) : (ce && pick(a2, a4, ci));
        le = ce && pick(sl, sf, ci);
        if (t == 0) check(int'(dot_en & char_en & adr_en & load_en), 1, "R8", "phase zero after reset");
        check(int'(dot_en),  int'(de), "R1", $sformatf("dot_en cfg %0d t %0d", cfgv, t));
        check(int'(char_en), int'(ce), "R2", $sformatf("char_en cfg %0d t %0d", cfgv, t));
        check(int'(adr_en),  int'(ae), (a2 && a4) ? "R4" : "R3", $sformatf("adr_en cfg %0d t %0d", cfgv, t));
        check(int'(load_en), int'(le), "R5", $sformatf("load_en cfg %0d t %0d", cfgv, t));
        @(negedge clk);
      end
    end

    // R9: switch 8 -> 9 dots mid-character; starts expected at t = 0, 8, 17
    start(8'b0100_0000);
    for (int t = 0; t < 30; t++) begin
      bit ce;
      ce = (t == 0 || t == 8 || t == 17 || t == 26);
      check(int'(char_en), int'(ce), "R9", $sformatf("char_en after mid change t %0d", t));
      if (t == 3) eight_dot = 0;
      @(negedge clk);
    end

    // R6/R7: seven isolated retrace pulses per line-control setting
    for (int lc = 0; lc < 4; lc++) begin
      bit ld, sd;
      int ev, er;
      ld = lc[1]; sd = lc[0];
      start({6'b010000, ld, sd});
      vc_seen = 0; row_seen = 0; count_on = 1;
      for (int k = 0; k < 7; k++) begin
        hretrace = 1;
        @(negedge clk);
        hretrace = 0;
        repeat (5) @(negedge clk);
      end
      count_on = 0;
      ev = ld ? 4 : 7;
      er = sd ? (ev + 1) / 2 : ev;
      check(vc_seen,  ev, "R6", $sformatf("vcnt_en pulses line_div2=%0d", ld));
      check(row_seen, er, "R7", $sformatf("row_en pulses scan_dbl=%0d line_div2=%0d", sd, ld));
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule